// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Command Master

This block drives a three-wire serial EEPROM that has 7-bit word addresses. The host gives a command code, an address, write data and a word-size select, then pulses `start`. The block then builds every frame the operation needs and shifts it out on select, clock and data-out lines. On a read it collects the reply from the data-in line. After every erase or write it polls the device's ready level. The host sees `busy` while the sequence runs, a one-cycle `done` at the end, the last read word on `rdata`, and a sticky `timeout_err` if a ready poll ran out of time.

A write request is a full sequence: enable, erase of the target word, ready poll, the program frame, a second ready poll, and a closing disable frame. A read takes one extra clock after the address, because the device answers with a leading zero bit that the block drops. The serial clock is derived from the system clock. Each of its half periods lasts `clk_div + 1` system cycles.

Top module: `uwire_eeprom_master`

## Requirements
- R1: While and right after reset, `mw_cs`, `mw_sck`, `mw_mosi`, `busy`, `done` and `timeout_err` are 0 and `rdata` is 0.
- R2: Each frame begins with a 1 bit, then a 2-bit opcode, then a 7-bit address field, all sent MSB first. The opcodes are read 10, write 01 and erase 11. Enable is 00 with address field 1100000, and disable is 00 with address field 0000000. Enable, disable and erase frames are exactly 10 bits long.
- R3: A write frame appends its data after the address. When `org16`=0 the data is 8 bits taken from `wdata[7:0]`. When `org16`=1 it is 16 bits taken from `wdata[15:0]`.
- R4: A read frame carries 1+N clocks after the address (N = 8 or 16), and `mw_mosi` is 0 during them. The first captured bit is dropped. The next N bits, MSB first, land in `rdata`, zero-extended when N=8. `rdata` changes only while `busy` is high.
- R5: The `cmd` codes are read 0, write 1, erase 2, enable 3 and disable 4. A write issues enable, erase, poll, write, poll and disable, in that order. An erase issues enable, erase, poll and disable. Codes 3 and 4 each issue one frame. Codes 0 and 4 issue no enable. Codes 5 to 7 issue no frame.
- R6: `mw_sck` stays in each level for `clk_div`+1 system cycles. `mw_mosi` never changes while `mw_sck` is high.
- R7: `mw_cs` is high from before the first clock rise of a frame until the last clock fall. Between any two frames or polls it stays low for at least 2·(`clk_div`+1) cycles, and `mw_sck` is low whenever `mw_cs` is low.
- R8: During a poll `mw_cs` is high and `mw_sck` stays low. A high `mw_miso` ends the poll. If `mw_miso` stays low, the poll ends after `poll_limit`+1 cycles of `mw_cs` high, `timeout_err` is set, and the sequence jumps straight to the disable frame.
- R9: `busy` rises the cycle after an accepted `start` and falls the cycle after `done`, which lasts one cycle. A `start` seen while `busy` is ignored.
- R10: `timeout_err` holds its value until the next accepted `start`, which clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a command when idle |
| cmd | input | 3 | Command code |
| addr | input | 7 | Word address |
| wdata | input | 16 | Write data |
| org16 | input | 1 | 1 selects 16-bit words, 0 selects 8-bit |
| clk_div | input | 8 | Serial half period minus one, in system cycles |
| poll_limit | input | 24 | Ready-poll timeout, in system cycles |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Last word read |
| timeout_err | output | 1 | Last ready poll timed out |
| mw_cs | output | 1 | Device select, active high |
| mw_sck | output | 1 | Serial clock |
| mw_mosi | output | 1 | Serial data to device |
| mw_miso | input | 1 | Serial data / ready level from device |

## Verification
The properties assume that `cmd`, `addr`, `wdata`, `org16`, `clk_div` and `poll_limit` are held steady from the accepted `start` until `done`. This matters most for the clock-division and gap checks, which read `clk_div` live. The stimulus changes these inputs only while `busy` is low. It fires a second `start` mid-sequence only to test that it is ignored, and it leaves the other inputs untouched at that moment. The device model changes `mw_miso` only between the master's sample points.

// File: rtl/uwire_eeprom_master.sv
module uwire_eeprom_master #(
  parameter int ADDR_W = 7,
  parameter int DIV_W  = 8,
  parameter int TMO_W  = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [2:0]        cmd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       wdata,
  input  logic              org16,
  input  logic [DIV_W-1:0]  clk_div,
  input  logic [TMO_W-1:0]  poll_limit,
  output logic              busy,
  output logic              done,
  output logic [15:0]       rdata,
  output logic              timeout_err,
  output logic              mw_cs,
  output logic              mw_sck,
  output logic              mw_mosi,
  input  logic              mw_miso
);

  localparam int HEAD_W  = 3 + ADDR_W;
  localparam int FRAME_W = HEAD_W + 16;
  localparam int CNT_W   = $clog2(FRAME_W + 2);
  localparam int HC_W    = DIV_W + 1;

  localparam logic [2:0] C_RD = 3'd0, C_WR = 3'd1, C_ER = 3'd2, C_EN = 3'd3, C_DS = 3'd4;

  typedef enum logic [2:0] {PH_IDLE, PH_GAP, PH_LO, PH_HI, PH_POLL, PH_FIN} ph_e;
  typedef enum logic [3:0] {ST_NONE, ST_EN, ST_ER, ST_PL1, ST_WR, ST_PL2, ST_DS, ST_RD, ST_END} st_e;

  ph_e               ph;
  st_e               step, nxt;
  logic [2:0]        cmd_q;
  logic [ADDR_W-1:0] addr_q;
  logic [15:0]       data_q;
  logic              org_q;
  logic [HC_W-1:0]   hcnt;
  logic [CNT_W-1:0]  bcnt;
  logic [FRAME_W-1:0] shreg;
  logic [15:0]       rx;
  logic [TMO_W-1:0]  tcnt;

  logic [HEAD_W-1:0] ld_head;
  logic [15:0]       ld_pay;
  logic [CNT_W-1:0]  ld_len;
  logic              nxt_frame, nxt_poll;
  logic [HC_W-1:0]   gap_ld, half_ld;

  assign busy    = (ph != PH_IDLE);
  assign done    = (ph == PH_FIN);
  assign mw_mosi = ((ph == PH_LO) || (ph == PH_HI)) && shreg[FRAME_W-1];
  assign gap_ld  = {clk_div, 1'b1};
  assign half_ld = {1'b0, clk_div};

  always_comb begin
    nxt = ST_END;
    unique case (step)
      ST_NONE: begin
        case (cmd_q)
          C_RD:             nxt = ST_RD;
          C_WR, C_ER, C_EN: nxt = ST_EN;
          C_DS:             nxt = ST_DS;
          default:          nxt = ST_END;
        endcase
      end
      ST_EN:   nxt = (cmd_q == C_EN) ? ST_END : ST_ER;
      ST_ER:   nxt = ST_PL1;
      ST_PL1:  nxt = (cmd_q == C_WR && !timeout_err) ? ST_WR : ST_DS;
      ST_WR:   nxt = ST_PL2;
      ST_PL2:  nxt = ST_DS;
      default: nxt = ST_END;
    endcase
  end

  assign nxt_poll  = (nxt == ST_PL1) || (nxt == ST_PL2);
  assign nxt_frame = (nxt == ST_EN) || (nxt == ST_ER) || (nxt == ST_WR) ||
                     (nxt == ST_DS) || (nxt == ST_RD);

  always_comb begin
    ld_head = '0;
    ld_pay  = '0;
    ld_len  = CNT_W'(HEAD_W);
    case (nxt)
      ST_EN: ld_head = {3'b100, 2'b11, {(ADDR_W-2){1'b0}}};
      ST_DS: ld_head = {3'b100, {ADDR_W{1'b0}}};
      ST_ER: ld_head = {3'b111, addr_q};
      ST_WR: begin
        ld_head = {3'b101, addr_q};
        ld_pay  = org_q ? data_q : {data_q[7:0], 8'h00};
        ld_len  = CNT_W'(HEAD_W + (org_q ? 16 : 8));
      end
      ST_RD: begin
        ld_head = {3'b110, addr_q};
        ld_len  = CNT_W'(HEAD_W + 1 + (org_q ? 16 : 8));
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph          <= PH_IDLE;
      step        <= ST_NONE;
      cmd_q       <= '0;
      addr_q      <= '0;
      data_q      <= '0;
      org_q       <= 1'b0;
      hcnt        <= '0;
      bcnt        <= '0;
      shreg       <= '0;
      rx          <= '0;
      tcnt        <= '0;
      rdata       <= '0;
      timeout_err <= 1'b0;
      mw_cs       <= 1'b0;
      mw_sck      <= 1'b0;
    end else begin
      unique case (ph)
        PH_IDLE: if (start) begin
          cmd_q       <= cmd;
          addr_q      <= addr;
          data_q      <= wdata;
          org_q       <= org16;
          timeout_err <= 1'b0;
          step        <= ST_NONE;
          hcnt        <= gap_ld;
          ph          <= PH_GAP;
        end
        PH_GAP: begin
          if (hcnt != '0) hcnt <= hcnt - HC_W'(1);
          else begin
            step <= nxt;
            if (nxt_frame) begin
              shreg <= {ld_head, ld_pay};
              bcnt  <= ld_len;
              mw_cs <= 1'b1;
              hcnt  <= half_ld;
              ph    <= PH_LO;
            end else if (nxt_poll) begin
              mw_cs <= 1'b1;
              tcnt  <= '0;
              ph    <= PH_POLL;
            end else begin
              ph <= PH_FIN;
            end
          end
        end
        PH_LO: begin
          if (hcnt != '0) hcnt <= hcnt - HC_W'(1);
          else begin
            mw_sck <= 1'b1;
            rx     <= {rx[14:0], mw_miso};
            hcnt   <= half_ld;
            ph     <= PH_HI;
          end
        end
        PH_HI: begin
          if (hcnt != '0) hcnt <= hcnt - HC_W'(1);
          else begin
            mw_sck <= 1'b0;
            shreg  <= shreg << 1;
            bcnt   <= bcnt - CNT_W'(1);
            if (bcnt == CNT_W'(1)) begin
              mw_cs <= 1'b0;
              hcnt  <= gap_ld;
              ph    <= PH_GAP;
              if (step == ST_RD) rdata <= org_q ? rx : {8'h00, rx[7:0]};
            end else begin
              hcnt <= half_ld;
              ph   <= PH_LO;
            end
          end
        end
        PH_POLL: begin
          if (mw_miso) begin
            mw_cs <= 1'b0;
            hcnt  <= gap_ld;
            ph    <= PH_GAP;
          end else if (tcnt == poll_limit) begin
            timeout_err <= 1'b1;
            mw_cs       <= 1'b0;
            hcnt        <= gap_ld;
            ph          <= PH_GAP;
          end else begin
            tcnt <= tcnt + TMO_W'(1);
          end
        end
        PH_FIN:  ph <= PH_IDLE;
        default: ph <= PH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/uwire_eeprom_master_chk.sv
module uwire_eeprom_master_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        busy,
  input logic        done,
  input logic [15:0] rdata,
  input logic        timeout_err,
  input logic        mw_cs,
  input logic        mw_sck,
  input logic        mw_mosi
);

  p_reset_quiet_r1: assert property (@(posedge clk) !rst_n |=> !mw_cs && !busy && !timeout_err);

  p_rdata_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(rdata));

  p_mosi_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mw_sck && $past(mw_sck) |-> $stable(mw_mosi));

  p_sck_in_frame_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !mw_cs |-> !mw_sck);

  p_cs_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mw_cs) |=> !mw_cs);

  p_timeout_ends_poll_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_err) |-> busy && !mw_cs);

  p_start_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> busy);

  p_done_in_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy);

  p_err_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> !timeout_err);

endmodule

bind uwire_eeprom_master uwire_eeprom_master_chk i_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .rdata(rdata), .timeout_err(timeout_err), .mw_cs(mw_cs), .mw_sck(mw_sck),
  .mw_mosi(mw_mosi)
);

// File: tb/test_uwire_eeprom_master.sv
module test_uwire_eeprom_master;
  timeunit 1ns; timeprecision 1ps;

  logic clk = 0, rst_n = 0, start = 0, org16 = 0;
  logic [2:0]  cmd = 0;
  logic [6:0]  addr = 0;
  logic [15:0] wdata = 0;
  logic [7:0]  clk_div = 8'd1;
  logic [23:0] poll_limit = 24'd40;
  logic busy, done, timeout_err, mw_cs, mw_sck, mw_mosi, mw_miso;
  logic [15:0] rdata;

  uwire_eeprom_master i_uwire_eeprom_master (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd(cmd), .addr(addr), .wdata(wdata),
    .org16(org16), .clk_div(clk_div), .poll_limit(poll_limit), .busy(busy), .done(done),
    .rdata(rdata), .timeout_err(timeout_err), .mw_cs(mw_cs), .mw_sck(mw_sck),
    .mw_mosi(mw_mosi), .mw_miso(mw_miso));

  always #2.5 clk = ~clk;

  int n_cmp = 0, n_bad = 0, cyc = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  longint exp_n[$], exp_v[$], exp_d[$];
  string  exp_t[$];

  task automatic want(input int n, input longint v, input int d, input string t);
    exp_n.push_back(n); exp_v.push_back(v); exp_d.push_back(d); exp_t.push_back(t);
  endtask

  function automatic longint hd(input int op, input int a);
    return longint'((1 << 9) | (op << 7) | a);
  endfunction

  // device model
  logic [15:0] mem [128];
  bit  wen = 0, dev_stuck = 0;
  int  dbusy = 0, dev_delay = 20;
  int  dcnt = 0;
  longint dval = 0;
  bit cs_p = 0, sck_p = 0, mosi_p = 0, done_p = 0, exp_busy = 0, have_fall = 0;
  int t_fall = 0, t_rise = 0, t_sr = 0, t_sf = 0;

  always_comb begin
    logic [63:0] hv;
    int j, n;
    mw_miso = 1'b0;
    hv = '0; j = 0; n = 0;
    if (mw_cs) begin
      if (dcnt == 0) mw_miso = !dev_stuck && (dbusy == 0);
      else if (dcnt >= 11) begin
        hv = dval >> (dcnt - 10);
        n  = org16 ? 16 : 8;
        j  = dcnt - 11;
        if (hv[8:7] == 2'b10 && j < n) mw_miso = mem[hv[6:0]][n-1-j];
      end
    end
  end

  task automatic frame_end();
    longint hv;
    int n;
    if (exp_n.size() == 0) chk(0, "R5 unexpected frame", dcnt, 0);
    else begin
      longint en, ev, ed;
      string t;
      en = exp_n.pop_front(); ev = exp_v.pop_front(); ed = exp_d.pop_front(); t = exp_t.pop_front();
      chk(dcnt == en, {t, " frame length"}, dcnt, en);
      chk(dval == ev, {t, " frame bits"}, dval, ev);
      if (ed >= 0) chk(cyc - t_rise == ed, {t, " poll length"}, cyc - t_rise, ed);
    end
    n = org16 ? 16 : 8;
    if (dcnt >= 10) begin
      hv = dval >> (dcnt - 10);
      if (hv[8:7] == 2'b00 && dcnt == 10) begin
        if (hv[6:5] == 2'b11) wen = 1;
        else if (hv[6:5] == 2'b00) wen = 0;
      end
      if (hv[8:7] == 2'b11 && dcnt == 10 && wen) begin
        mem[hv[6:0]] = 16'hFFFF; dbusy = dev_delay;
      end
      if (hv[8:7] == 2'b01 && dcnt == 10 + n && wen) begin
        mem[hv[6:0]] = mem[hv[6:0]] & (org16 ? dval[15:0] : {8'hFF, dval[7:0]});
        dbusy = dev_delay;
      end
    end
  endtask

  always @(negedge clk) begin
    int h;
    h = int'(clk_div) + 1;
    if (rst_n) begin
      cyc++;
      if (start && !exp_busy) exp_busy = 1;
      if (done_p) exp_busy = 0;
      chk(busy === exp_busy, "R9 busy model", busy, exp_busy);
      if (mw_cs && !cs_p) begin
        if (have_fall) chk(cyc - t_fall >= 2*h, "R7 deselect gap", cyc - t_fall, 2*h);
        dcnt = 0; dval = 0; t_rise = cyc;
      end
      if (mw_cs && mw_sck && !sck_p) begin
        if (dcnt > 0) chk(cyc - t_sf == h, "R6 sck low time", cyc - t_sf, h);
        else chk(cyc - t_rise == h, "R7 select to first rise", cyc - t_rise, h);
        dval = (dval << 1) | longint'(mw_mosi);
        dcnt++;
        t_sr = cyc;
      end
      if (!mw_sck && sck_p) begin
        chk(cyc - t_sr == h, "R6 sck high time", cyc - t_sr, h);
        t_sf = cyc;
      end
      if (mw_sck && sck_p) chk(mw_mosi == mosi_p, "R6 mosi stable while high", mw_mosi, mosi_p);
      if (!mw_cs && cs_p) begin
        frame_end();
        t_fall = cyc; have_fall = 1;
      end
      if (dbusy > 0) dbusy--;
      cs_p = mw_cs; sck_p = mw_sck; mosi_p = mw_mosi; done_p = done;
    end
  end

  task automatic issue(input logic [2:0] c, input logic [6:0] a, input logic [15:0] d, input logic o);
    @(negedge clk); #1;
    cmd = c; addr = a; wdata = d; org16 = o; start = 1;
    @(negedge clk); #1;
    start = 0;
  endtask

  task automatic finish_cmd(input bit terr, input string t);
    while (!done) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(exp_n.size() == 0, "R5 all frames issued", exp_n.size(), 0);
    chk(timeout_err == terr, t, timeout_err, terr);
  endtask

  task automatic exp_write(input int a, input int d, input bit o, input int pl_dur);
    int n;
    n = o ? 16 : 8;
    want(10, hd(0, 7'h60), -1, "R2 enable");
    want(10, hd(3, a), -1, "R2 erase");
    want(0, 0, pl_dur, "R8 poll");
    if (pl_dur < 0) begin
      want(10 + n, (hd(1, a) << n) | longint'(o ? d : (d & 8'hFF)), -1, "R3 write data");
      want(0, 0, -1, "R8 poll");
    end
    want(10, hd(0, 0), -1, "R2 disable");
  endtask

  task automatic exp_read(input int a, input bit o);
    int n;
    n = o ? 16 : 8;
    want(11 + n, hd(2, a) << (1 + n), -1, "R4 read frame");
  endtask

  initial begin
    for (int i = 0; i < 128; i++) mem[i] = 16'h0000;
    repeat (4) @(negedge clk);
    chk(mw_cs === 0 && mw_sck === 0 && mw_mosi === 0, "R1 serial lines in reset", {mw_cs, mw_sck, mw_mosi}, 0);
    chk(busy === 0 && done === 0 && timeout_err === 0, "R1 status in reset", {busy, done, timeout_err}, 0);
    chk(rdata === 16'h0, "R1 rdata in reset", rdata, 0);
    rst_n = 1;
    @(negedge clk);
    chk(busy === 0 && mw_cs === 0, "R1 idle after reset", {busy, mw_cs}, 0);

    // R5: standalone enable
    want(10, hd(0, 7'h60), -1, "R5 enable only");
    issue(3'd3, 7'h11, 16'h0, 0);
    finish_cmd(0, "R8 no timeout");

    // R3/R5: byte write, then read back (R4)
    clk_div = 8'd1;
    exp_write(7'h15, 16'h12A5, 0, -1);
    issue(3'd1, 7'h15, 16'h12A5, 0);
    finish_cmd(0, "R8 no timeout on write");
    exp_read(7'h15, 0);
    issue(3'd0, 7'h15, 16'h0, 0);
    finish_cmd(0, "R8 no timeout on read");
    chk(rdata == 16'h00A5, "R4 byte read", rdata, 16'h00A5);

    // 16-bit words at a slower serial clock
    clk_div = 8'd3;
    exp_write(7'h7F, 16'hBEEF, 1, -1);
    issue(3'd1, 7'h7F, 16'hBEEF, 1);
    finish_cmd(0, "R8 no timeout on word write");
    exp_read(7'h7F, 1);
    issue(3'd0, 7'h7F, 16'h0, 1);
    finish_cmd(0, "R8 no timeout on word read");
    chk(rdata == 16'hBEEF, "R4 word read", rdata, 16'hBEEF);

    // R5: erase sequence, then read at fastest clock
    clk_div = 8'd0;
    want(10, hd(0, 7'h60), -1, "R5 erase enable");
    want(10, hd(3, 7'h15), -1, "R5 erase frame");
    want(0, 0, -1, "R5 erase poll");
    want(10, hd(0, 0), -1, "R5 erase disable");
    issue(3'd2, 7'h15, 16'h0, 0);
    finish_cmd(0, "R8 no timeout on erase");
    exp_read(7'h15, 0);
    issue(3'd0, 7'h15, 16'h0, 0);
    finish_cmd(0, "R8 no timeout");
    chk(rdata == 16'h00FF, "R4 read erased byte", rdata, 16'h00FF);

    // R8: device never ready
    clk_div = 8'd1;
    dev_stuck = 1;
    exp_write(7'h03, 16'h0055, 0, 41);
    issue(3'd1, 7'h03, 16'h0055, 0);
    finish_cmd(1, "R8 timeout flagged");
    repeat (5) @(negedge clk);
    chk(timeout_err == 1, "R10 error holds while idle", timeout_err, 1);
    dev_stuck = 0;

    // R10: next start clears the flag; R5 disable only
    want(10, hd(0, 0), -1, "R5 disable only");
    issue(3'd4, 7'h00, 16'h0, 0);
    finish_cmd(0, "R10 error cleared by start");

    // R5: unused code issues nothing
    issue(3'd7, 7'h22, 16'h0, 0);
    finish_cmd(0, "R5 unused code");
    chk(rdata == 16'h00FF, "R4 rdata unchanged by non-read", rdata, 16'h00FF);

    // R9: start during busy is ignored
    exp_read(7'h7F, 1);
    issue(3'd0, 7'h7F, 16'h0, 1);
    repeat (6) @(negedge clk);
    #1; cmd = 3'd1; start = 1;
    @(negedge clk); #1; start = 0; cmd = 3'd0;
    finish_cmd(0, "R9 no error after ignored start");
    chk(rdata == 16'hBEEF, "R9 first command completed", rdata, 16'hBEEF);
    repeat (40) @(negedge clk);
    chk(busy == 0 && exp_n.size() == 0, "R9 ignored start issued nothing", busy, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(5ns * 150000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog R9 actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule